// File: doc/BRIEF.md
# Shadow Task-File PIO Command Sequencer

This block runs one legacy programmed-I/O command on a serial ATA host port. Software fills a shadow task file of byte-wide registers over a small register bus. The registers hold features, sector count, three address bytes and device/head. A write to the command slot at the top of the eight-byte window starts the command. The sequencer then presents one host-to-device register frame, built from the shadow contents, on a valid/ready transmit port.

After the frame is taken, the block waits for the device's answer on an abstract receive port. A PIO setup frame loads the shadow registers and the initial status, and opens a data phase whose direction comes from the frame. The frame's ending status is kept in a private holding register. It reaches the visible status register only when the data phase reports that the last data was accepted. A device-to-host register frame instead ends the command at once. Either frame can raise the interrupt output. A status read clears the interrupt, and so does a soft reset. The soft reset also returns the sequencer to idle. The physical layer, link layer, CRC and the data movement itself lie outside the block.

Top module: `pio_cmd_seq`

## Requirements
- R1: After reset, the status register reads 00h, and `irq`, `h2d_valid` and `xfer_active` are 0.
- R2: The task file occupies eight byte addresses starting at parameter `TF_BASE` (default 1F0h). Offsets 1 to 6 are features/error, count, address low, address mid, address high and device. A write at offsets 1 to 6 stores the byte and starts nothing. Only a write at offset 7 starts a command. Accesses outside the window, such as 177h with the default base, are ignored and read 00h.
- R3: In the cycle after an accepted command write, `h2d_valid` is 1 and stays 1 until `h2d_ready` is seen. The frame layout is bits [7:0]=27h, [15:8]=command, [23:16]=features, [31:24]/[39:32]/[47:40]=address low/mid/high, [55:48]=device and [63:56]=count.
- R4: Status bit 7 (busy) reads 1 from the cycle after the command write until the command completes. A command write made while busy is ignored, and the command byte in the pending frame keeps its value.
- R5: While waiting, a frame of type 5Fh loads status, error, count, address and device into the shadow registers. It then starts the data phase: `xfer_active` becomes 1 and `xfer_to_host` equals `rx_dir`.
- R6: The ending status of a 5Fh frame stays hidden while the data phase lasts. In the cycle after `data_done`, status reads that ending status, busy clears and `xfer_active` falls.
- R7: A 5Fh or 34h frame with `rx_irq`=1 sets `irq` in the next cycle. If `rx_irq` is 0, the frame leaves `irq` low. `irq` stays set until a read strobe at offset 7 or a soft reset.
- R8: While waiting, a frame of type 34h loads status and error and completes the command in the next cycle, with no data phase.
- R9: Frames of any other type while waiting, and any frame outside the waiting state, change neither the registers nor the state.
- R10: `soft_rst` returns the block to idle in the next cycle: `h2d_valid`, `xfer_active`, `irq` and busy drop. After that, a new command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | Synchronous return to idle, clears interrupt and held status |
| reg_addr | input | 10 | Register bus byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears interrupt at offset 7) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| h2d_valid | output | 1 | Host-to-device register frame pending |
| h2d_ready | input | 1 | Transmitter takes the frame |
| h2d_frame | output | 64 | Frame contents |
| rx_valid | input | 1 | Received frame present for one cycle |
| rx_type | input | 8 | Received frame type code |
| rx_irq | input | 1 | Interrupt bit of the received frame |
| rx_dir | input | 1 | Data direction of a PIO setup frame, 1 = device to host |
| rx_status | input | 8 | Status byte of the frame |
| rx_error | input | 8 | Error byte of the frame |
| rx_estatus | input | 8 | Ending status byte of a PIO setup frame |
| rx_count | input | 8 | Count byte of the frame |
| rx_lba | input | 24 | Address bytes, low byte in [7:0] |
| rx_dev | input | 8 | Device byte of the frame |
| data_done | input | 1 | Last data of the data phase accepted |
| irq | output | 1 | Pending interrupt |
| xfer_active | output | 1 | Data phase in progress |
| xfer_to_host | output | 1 | Direction of the current data phase |

## Verification
The main flow runs in three forms: a write-direction PIO setup with the interrupt bit set, a read-direction PIO setup without it, and a direct register-frame ending. Between them they separate held from immediate status loading, the data direction, and interrupt set against interrupt left clear. Parameter writes before the command, command writes while busy, writes outside the address window, stray frame types and frames arriving while idle show that only the intended events start or change anything. A soft reset during the data phase and during the transmit wait shows that both exits return cleanly to idle.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    typedef logic [7:0] byte_t;

    // frame type codes
    localparam byte_t FT_H2D_REG   = 8'h27;
    localparam byte_t FT_D2H_REG   = 8'h34;
    localparam byte_t FT_PIO_SETUP = 8'h5F;
    localparam byte_t FT_DATA      = 8'h46;

    localparam int BSY_BIT     = 7;
    localparam int FRAME_BYTES = 8;
    localparam int FRAME_W     = 8 * FRAME_BYTES;
    localparam int LBA_BYTES   = 3;

    // offsets inside the eight-byte task-file window
    localparam logic [2:0] OFF_DATA  = 3'd0;
    localparam logic [2:0] OFF_FEAT  = 3'd1;
    localparam logic [2:0] OFF_COUNT = 3'd2;
    localparam logic [2:0] OFF_LBA0  = 3'd3;
    localparam logic [2:0] OFF_LBA1  = 3'd4;
    localparam logic [2:0] OFF_LBA2  = 3'd5;
    localparam logic [2:0] OFF_DEV   = 3'd6;
    localparam logic [2:0] OFF_CMD   = 3'd7;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SEND,
        SQ_WAIT,
        SQ_DATA
    } seq_state_e;

    typedef struct packed {
        byte_t                   feat;
        byte_t                   count;
        byte_t [LBA_BYTES-1:0]   lba;
        byte_t                   dev;
        byte_t                   cmd;
        byte_t                   status;
        byte_t                   error;
    } shadow_t;

    typedef struct packed {
        byte_t                   status;
        byte_t                   error;
        byte_t                   count;
        byte_t [LBA_BYTES-1:0]   lba;
        byte_t                   dev;
    } rx_fields_t;

    typedef struct packed {
        seq_state_e state;
        byte_t      estatus;
        logic       irq;
        logic       to_host;
    } seq_regs_t;

endpackage

// File: rtl/tf_shadow_regs.sv
module tf_shadow_regs
    import pio_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [2:0] host_off,
    input  byte_t      host_data,
    input  logic       cmd_take,
    input  logic       frm_ld,
    input  rx_fields_t frm,
    input  logic       st_ld,
    input  byte_t      st_val,
    input  logic       busy,
    input  logic [2:0] rd_off,
    output byte_t      rd_data,
    output shadow_t    sh
);

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (host_wr) begin
            case (host_off)
                OFF_FEAT:  sh_d.feat   = host_data;
                OFF_COUNT: sh_d.count  = host_data;
                OFF_LBA0:  sh_d.lba[0] = host_data;
                OFF_LBA1:  sh_d.lba[1] = host_data;
                OFF_LBA2:  sh_d.lba[2] = host_data;
                OFF_DEV:   sh_d.dev    = host_data;
                OFF_CMD:   if (cmd_take) sh_d.cmd = host_data;
                default:   ;
            endcase
        end
        if (frm_ld) begin
            sh_d.status = frm.status;
            sh_d.error  = frm.error;
            sh_d.count  = frm.count;
            sh_d.lba    = frm.lba;
            sh_d.dev    = frm.dev;
        end
        if (st_ld) begin
            sh_d.status = st_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    always_comb begin
        case (rd_off)
            OFF_FEAT:  rd_data = sh_q.error;
            OFF_COUNT: rd_data = sh_q.count;
            OFF_LBA0:  rd_data = sh_q.lba[0];
            OFF_LBA1:  rd_data = sh_q.lba[1];
            OFF_LBA2:  rd_data = sh_q.lba[2];
            OFF_DEV:   rd_data = sh_q.dev;
            OFF_CMD: begin
                rd_data          = sh_q.status;
                rd_data[BSY_BIT] = sh_q.status[BSY_BIT] | busy;
            end
            default:   rd_data = '0;
        endcase
    end

    assign sh = sh_q;

endmodule

// File: rtl/h2d_frame_pack.sv
module h2d_frame_pack
    import pio_seq_pkg::*;
(
    input  byte_t                 cmd,
    input  byte_t                 feat,
    input  byte_t [LBA_BYTES-1:0] lba,
    input  byte_t                 dev,
    input  byte_t                 count,
    output logic [FRAME_W-1:0]    frame
);

    byte_t [FRAME_BYTES-1:0] fb;

    assign fb[0] = FT_H2D_REG;
    assign fb[1] = cmd;
    assign fb[2] = feat;

    for (genvar g = 0; g < LBA_BYTES; g++) begin : g_lba
        assign fb[3+g] = lba[g];
    end

    assign fb[3+LBA_BYTES] = dev;
    assign fb[4+LBA_BYTES] = count;

    assign frame = fb;

endmodule

// File: rtl/pio_seq_ctrl.sv
module pio_seq_ctrl
    import pio_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  soft_rst,
    input  logic  cmd_wr,
    input  logic  st_rd,
    input  logic  tx_ready,
    input  logic  rx_valid,
    input  byte_t rx_type,
    input  logic  rx_irq,
    input  logic  rx_dir,
    input  byte_t rx_estatus,
    input  logic  data_done,
    output logic  cmd_take,
    output logic  tx_valid,
    output logic  frm_ld,
    output logic  st_ld,
    output byte_t st_val,
    output logic  busy,
    output logic  irq,
    output logic  xfer_active,
    output logic  xfer_to_host
);

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        cmd_take = 1'b0;
        frm_ld   = 1'b0;
        st_ld    = 1'b0;

        if (st_rd) r_d.irq = 1'b0;

        case (r_q.state)
            SQ_IDLE: begin
                if (cmd_wr) begin
                    cmd_take  = 1'b1;
                    r_d.state = SQ_SEND;
                end
            end
            SQ_SEND: begin
                if (tx_ready) r_d.state = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (rx_valid && rx_type == FT_PIO_SETUP) begin
                    frm_ld      = 1'b1;
                    r_d.estatus = rx_estatus;
                    r_d.to_host = rx_dir;
                    r_d.state   = SQ_DATA;
                    if (rx_irq) r_d.irq = 1'b1;
                end else if (rx_valid && rx_type == FT_D2H_REG) begin
                    frm_ld    = 1'b1;
                    r_d.state = SQ_IDLE;
                    if (rx_irq) r_d.irq = 1'b1;
                end
            end
            SQ_DATA: begin
                if (data_done) begin
                    st_ld     = 1'b1;
                    r_d.state = SQ_IDLE;
                end
            end
            default: r_d.state = SQ_IDLE;
        endcase

        if (soft_rst) begin
            r_d      = '0;
            cmd_take = 1'b0;
            frm_ld   = 1'b0;
            st_ld    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign st_val       = r_q.estatus;
    assign busy         = (r_q.state != SQ_IDLE);
    assign tx_valid     = (r_q.state == SQ_SEND);
    assign xfer_active  = (r_q.state == SQ_DATA);
    assign xfer_to_host = r_q.to_host;
    assign irq          = r_q.irq;

endmodule

// File: rtl/pio_cmd_seq.sv
module pio_cmd_seq
    import pio_seq_pkg::*;
#(
    parameter int                ADDR_W  = 10,
    parameter logic [ADDR_W-1:0] TF_BASE = 10'h1F0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               h2d_valid,
    input  logic               h2d_ready,
    output logic [63:0]        h2d_frame,
    input  logic               rx_valid,
    input  logic [7:0]         rx_type,
    input  logic               rx_irq,
    input  logic               rx_dir,
    input  logic [7:0]         rx_status,
    input  logic [7:0]         rx_error,
    input  logic [7:0]         rx_estatus,
    input  logic [7:0]         rx_count,
    input  logic [23:0]        rx_lba,
    input  logic [7:0]         rx_dev,
    input  logic               data_done,
    output logic               irq,
    output logic               xfer_active,
    output logic               xfer_to_host
);

    localparam int OFF_W = 3;

    logic       hit;
    logic [2:0] off;
    logic       host_wr, cmd_wr, st_rd;
    logic       cmd_take, frm_ld, st_ld, busy;
    byte_t      st_val, rd_data;
    shadow_t    sh;
    rx_fields_t rxf;

    assign hit     = (reg_addr[ADDR_W-1:OFF_W] == TF_BASE[ADDR_W-1:OFF_W]);
    assign off     = reg_addr[OFF_W-1:0];
    assign host_wr = reg_wr & hit;
    assign cmd_wr  = host_wr & (off == OFF_CMD);
    assign st_rd   = reg_rd & hit & (off == OFF_CMD);

    assign rxf.status = rx_status;
    assign rxf.error  = rx_error;
    assign rxf.count  = rx_count;
    assign rxf.lba    = rx_lba;
    assign rxf.dev    = rx_dev;

    pio_seq_ctrl ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .cmd_wr       (cmd_wr),
        .st_rd        (st_rd),
        .tx_ready     (h2d_ready),
        .rx_valid     (rx_valid),
        .rx_type      (rx_type),
        .rx_irq       (rx_irq),
        .rx_dir       (rx_dir),
        .rx_estatus   (rx_estatus),
        .data_done    (data_done),
        .cmd_take     (cmd_take),
        .tx_valid     (h2d_valid),
        .frm_ld       (frm_ld),
        .st_ld        (st_ld),
        .st_val       (st_val),
        .busy         (busy),
        .irq          (irq),
        .xfer_active  (xfer_active),
        .xfer_to_host (xfer_to_host)
    );

    tf_shadow_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_off  (off),
        .host_data (reg_wdata),
        .cmd_take  (cmd_take),
        .frm_ld    (frm_ld),
        .frm       (rxf),
        .st_ld     (st_ld),
        .st_val    (st_val),
        .busy      (busy),
        .rd_off    (off),
        .rd_data   (rd_data),
        .sh        (sh)
    );

    h2d_frame_pack pack_i (
        .cmd   (sh.cmd),
        .feat  (sh.feat),
        .lba   (sh.lba),
        .dev   (sh.dev),
        .count (sh.count),
        .frame (h2d_frame)
    );

    assign reg_rdata = hit ? rd_data : 8'h00;

endmodule

// File: rtl/pio_cmd_seq_chk.sv
module pio_cmd_seq_chk #(
    parameter int                ADDR_W  = 10,
    parameter logic [ADDR_W-1:0] TF_BASE = 10'h1F0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              h2d_valid,
    input logic              h2d_ready,
    input logic [63:0]       h2d_frame,
    input logic              rx_valid,
    input logic              rx_irq,
    input logic              data_done,
    input logic              irq,
    input logic              xfer_active
);

    localparam logic [ADDR_W-1:0] CMD_ADDR = {TF_BASE[ADDR_W-1:3], 3'd7};

    a_r2_start_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h2d_valid) |-> ($past(reg_wr) && $past(reg_addr) == CMD_ADDR));

    a_r3_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        (h2d_valid && !h2d_ready && !soft_rst) |=> h2d_valid);

    a_r3_frame_type: assert property (@(posedge clk) disable iff (!rst_n)
        h2d_valid |-> (h2d_frame[7:0] == 8'h27));

    a_r6_data_end: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && data_done && !soft_rst) |=> !xfer_active);

    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(rx_valid && rx_irq));

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |-> !h2d_valid);

    a_r10_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!h2d_valid && !irq && !xfer_active));

endmodule

bind pio_cmd_seq pio_cmd_seq_chk #(.ADDR_W(ADDR_W), .TF_BASE(TF_BASE)) chk_i (.*);

// File: tb/pio_cmd_seq_tb_top.sv
module pio_cmd_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] BASE = 10'h1F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        h2d_valid;
    logic        h2d_ready = 1'b0;
    logic [63:0] h2d_frame;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_type = '0;
    logic        rx_irq = 1'b0;
    logic        rx_dir = 1'b0;
    logic [7:0]  rx_status = '0;
    logic [7:0]  rx_error = '0;
    logic [7:0]  rx_estatus = '0;
    logic [7:0]  rx_count = '0;
    logic [23:0] rx_lba = '0;
    logic [7:0]  rx_dev = '0;
    logic        data_done = 1'b0;
    logic        irq;
    logic        xfer_active;
    logic        xfer_to_host;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_cmd_seq dut_i (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_strobe(input logic [9:0] a);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ack_tx();
        @(negedge clk);
        h2d_ready = 1'b1;
        @(negedge clk);
        h2d_ready = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] t, input logic i, input logic dir,
                           input logic [7:0] st, input logic [7:0] er, input logic [7:0] es,
                           input logic [7:0] cnt, input logic [23:0] lba, input logic [7:0] dv);
        @(negedge clk);
        rx_valid = 1'b1; rx_type = t; rx_irq = i; rx_dir = dir;
        rx_status = st; rx_error = er; rx_estatus = es;
        rx_count = cnt; rx_lba = lba; rx_dev = dv;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        data_done = 1'b1;
        @(negedge clk);
        data_done = 1'b0;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(BASE + 10'd7, d);
        check("R1 status after reset", d, 8'h00);
        check("R1 irq after reset", irq, 1'b0);
        check("R1 h2d_valid after reset", h2d_valid, 1'b0);
        check("R1 xfer_active after reset", xfer_active, 1'b0);
    endtask

    task automatic t_write_flow();
        logic [7:0] d;
        wr(BASE + 10'd1, 8'h11);
        wr(BASE + 10'd2, 8'h22);
        wr(BASE + 10'd3, 8'h33);
        wr(BASE + 10'd4, 8'h44);
        wr(BASE + 10'd5, 8'h55);
        wr(BASE + 10'd6, 8'hE0);
        check("R2 no start on parameter writes", h2d_valid, 1'b0);
        rd(BASE + 10'd2, d);
        check("R2 count readback", d, 8'h22);
        rd(BASE + 10'd5, d);
        check("R2 lba high readback", d, 8'h55);
        wr(BASE + 10'd7, 8'h30);
        check("R3 valid after command", h2d_valid, 1'b1);
        check("R3 frame layout", h2d_frame, 64'h22E0_5544_3311_3027);
        repeat (2) @(negedge clk);
        check("R3 valid held without ready", h2d_valid, 1'b1);
        rd(BASE + 10'd7, d);
        check("R4 busy while sending", d[7], 1'b1);
        wr(BASE + 10'd7, 8'hEE);
        check("R4 command byte kept while busy", h2d_frame[15:8], 8'h30);
        ack_tx();
        check("R3 valid drops after ready", h2d_valid, 1'b0);
        repeat (2) @(negedge clk);
        check("R4 ignored command starts no frame", h2d_valid, 1'b0);
        send_rx(8'h5F, 1'b1, 1'b0, 8'h58, 8'h00, 8'h50, 8'h01, 24'h030201, 8'hA0);
        check("R5 data phase active", xfer_active, 1'b1);
        check("R5 direction host to device", xfer_to_host, 1'b0);
        rd(BASE + 10'd2, d);
        check("R5 count loaded from frame", d, 8'h01);
        rd(BASE + 10'd4, d);
        check("R5 lba mid loaded from frame", d, 8'h02);
        rd(BASE + 10'd6, d);
        check("R5 device loaded from frame", d, 8'hA0);
        check("R7 irq set by setup frame", irq, 1'b1);
        repeat (3) @(negedge clk);
        rd(BASE + 10'd7, d);
        check("R6 initial status visible during data", d, 8'hD8);
        pulse_done();
        rd(BASE + 10'd7, d);
        check("R6 ending status after done", d, 8'h50);
        check("R6 data phase ended", xfer_active, 1'b0);
        check("R7 irq held until status read", irq, 1'b1);
        rd_strobe(BASE + 10'd7);
        check("R7 irq cleared by status read", irq, 1'b0);
    endtask

    task automatic t_read_flow();
        logic [7:0] d;
        wr(BASE + 10'd7, 8'h20);
        check("R4 new command accepted after completion", h2d_valid, 1'b1);
        check("R3 new command byte", h2d_frame[15:8], 8'h20);
        ack_tx();
        send_rx(8'h5F, 1'b0, 1'b1, 8'h08, 8'h04, 8'h51, 8'h10, 24'h0000AA, 8'hB0);
        check("R5 direction device to host", xfer_to_host, 1'b1);
        check("R7 no irq without frame bit", irq, 1'b0);
        rd(BASE + 10'd1, d);
        check("R5 error loaded from frame", d, 8'h04);
        pulse_done();
        rd(BASE + 10'd7, d);
        check("R6 read ending status", d, 8'h51);
    endtask

    task automatic t_d2h_flow();
        logic [7:0] d;
        wr(BASE + 10'd7, 8'hEC);
        ack_tx();
        send_rx(8'h34, 1'b1, 1'b0, 8'h41, 8'h04, 8'h00, 8'h00, 24'h0, 8'h00);
        check("R8 no data phase", xfer_active, 1'b0);
        rd(BASE + 10'd7, d);
        check("R8 status direct and not busy", d, 8'h41);
        rd(BASE + 10'd1, d);
        check("R8 error direct", d, 8'h04);
        check("R7 irq from register frame", irq, 1'b1);
        rd_strobe(BASE + 10'd7);
        check("R7 irq cleared again", irq, 1'b0);
    endtask

    task automatic t_ignored_frames();
        logic [7:0] d;
        send_rx(8'h5F, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h77, 24'h0, 8'h00);
        rd(BASE + 10'd2, d);
        check("R9 idle frame leaves count", d, 8'h00);
        check("R9 idle frame leaves irq", irq, 1'b0);
        check("R9 idle frame starts nothing", xfer_active, 1'b0);
        wr(BASE + 10'd7, 8'h30);
        ack_tx();
        send_rx(pio_seq_pkg::FT_DATA, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h66, 24'h0, 8'h00);
        check("R9 stray type no data phase", xfer_active, 1'b0);
        rd(BASE + 10'd7, d);
        check("R9 stray type keeps busy", d[7], 1'b1);
        check("R9 stray type no irq", irq, 1'b0);
        send_rx(8'h34, 1'b0, 1'b0, 8'h50, 8'h00, 8'h00, 8'h00, 24'h0, 8'h00);
        rd(BASE + 10'd7, d);
        check("R8 completes after stray frame", d, 8'h50);
    endtask

    task automatic t_soft_reset();
        logic [7:0] d;
        wr(BASE + 10'd7, 8'h30);
        ack_tx();
        send_rx(8'h5F, 1'b1, 1'b0, 8'h58, 8'h00, 8'h50, 8'h01, 24'h0, 8'h00);
        check("R10 precondition data phase", xfer_active, 1'b1);
        pulse_soft();
        check("R10 irq cleared", irq, 1'b0);
        check("R10 data phase dropped", xfer_active, 1'b0);
        rd(BASE + 10'd7, d);
        check("R10 busy cleared", d[7], 1'b0);
        wr(BASE + 10'd7, 8'h31);
        check("R10 command after soft reset", h2d_valid, 1'b1);
        pulse_soft();
        check("R10 valid dropped while sending", h2d_valid, 1'b0);
    endtask

    task automatic t_foreign_addr();
        logic [7:0] d;
        wr(10'h177, 8'h30);
        check("R2 foreign command address ignored", h2d_valid, 1'b0);
        rd(10'h177, d);
        check("R2 foreign read is zero", d, 8'h00);
        wr(BASE, 8'h30);
        check("R2 data offset does not start", h2d_valid, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_flow();
        t_read_flow();
        t_d2h_flow();
        t_ignored_frames();
        t_soft_reset();
        t_foreign_addr();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule